// File: doc/BRIEF.md
# Video processor control port decoder

This block sits between a host CPU and a tile-based video display processor. It handles the byte-wide control port. Each command takes two control writes. The first write only captures a byte. The second write completes the command. It always loads a 14-bit video-memory address pointer, built from the captured byte (low half) and the low six bits of the new byte (high half). The top two bits of the new byte then select what the command does: a register write, a memory read setup, a memory write setup, or (in the extended variant) a switch of the data-port target to colour RAM.

Data-port reads and writes are handled elsewhere, but this block sees their strobes. Each strobe steps the pointer by one. A data-port access or a status read also returns the control port to its first phase, so the host can resynchronise the byte pairing. The `EXTENDED` parameter selects the variant that decodes the colour-RAM command.

Top module: `vdp_ctrl_port`

## Requirements
- R1: After reset `addr` is 0, `cram_sel` is 0, `reg_wr` and `rd_prefetch` are 0, and the next control write is treated as a first write.
- R2: A first-phase control write changes no output: `addr` holds, and no `reg_wr` or `rd_prefetch` pulse occurs.
- R3: A second-phase control write of byte B, after first byte L, sets `addr` to {B[5:0], L} one cycle later, whatever command B encodes.
- R4: After a second-phase write the phase returns to first, so a single following control write leaves `addr` unchanged.
- R5: A second byte with B[7]=1 (other than the colour-RAM command of R6) gives a one-cycle `reg_wr` pulse one cycle after the write, with `reg_idx`=B[IDX_W-1:0] and `reg_val`=L. With the default IDX_W=4 the index is B[3:0].
- R6: With EXTENDED=1, a second byte with B[7:6]=11 sets `cram_sel` to 1 and gives no `reg_wr` pulse. With EXTENDED=0 the same byte is an ordinary register write under R5.
- R7: A second byte with B[7:6]=00 gives a one-cycle `rd_prefetch` pulse one cycle after the write and clears `cram_sel`.
- R8: A second byte with B[7:6]=01 gives neither `rd_prefetch` nor `reg_wr`, and it clears `cram_sel`.
- R9: Each `data_rd` or `data_wr` strobe increments `addr` by one, and the pointer wraps from 0x3FFF to 0.
- R10: A `data_rd`, `data_wr` or `status_rd` strobe returns the phase to first. A `status_rd` strobe does not change `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_data | input | 8 | Control-port write byte |
| data_rd | input | 1 | Data-port read strobe |
| data_wr | input | 1 | Data-port write strobe |
| status_rd | input | 1 | Status read strobe |
| addr | output | ADDR_W | Video-memory address pointer |
| cram_sel | output | 1 | Data port targets colour RAM |
| rd_prefetch | output | 1 | One-cycle read prefetch request |
| reg_wr | output | 1 | One-cycle register write strobe |
| reg_idx | output | IDX_W | Register index for `reg_wr` |
| reg_val | output | 8 | Register value for `reg_wr` |

## Verification
The assertions assume that at most one of the four input strobes is high in any cycle. The host bus is taken never to issue a control write together with a data access or a status read, and one assertion checks this assumption. The bench drives each strobe on its own for exactly one cycle, with idle cycles between strobes. It also holds every strobe low through reset, so the pointer-step and phase checks never see overlapping strobes.

// File: rtl/vdp_ctrl_port.sv
module vdp_ctrl_port #(
  parameter int ADDR_W   = 14,
  parameter int IDX_W    = 4,
  parameter bit EXTENDED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [7:0]        ctrl_data,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              status_rd,
  output logic [ADDR_W-1:0] addr,
  output logic              cram_sel,
  output logic              rd_prefetch,
  output logic              reg_wr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [7:0]        reg_val
);
  localparam int HI_W = ADDR_W - 8;

  logic       second;
  logic [7:0] low_q;
  logic       is_cram;

  generate
    if (EXTENDED) begin : g_ext
      assign is_cram = ctrl_data[7] & ctrl_data[6];
    end else begin : g_std
      assign is_cram = 1'b0;
    end
  endgenerate

  wire finish   = ctrl_wr & second;
  wire data_acc = data_rd | data_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second      <= 1'b0;
      low_q       <= '0;
      addr        <= '0;
      cram_sel    <= 1'b0;
      rd_prefetch <= 1'b0;
      reg_wr      <= 1'b0;
      reg_idx     <= '0;
      reg_val     <= '0;
    end else begin
      rd_prefetch <= 1'b0;
      reg_wr      <= 1'b0;
      if (ctrl_wr && !second) begin
        low_q  <= ctrl_data;
        second <= 1'b1;
      end else if (finish) begin
        second <= 1'b0;
        addr   <= {ctrl_data[HI_W-1:0], low_q};
        if (ctrl_data[7]) begin
          if (is_cram) cram_sel <= 1'b1;
          else begin
            reg_wr  <= 1'b1;
            reg_idx <= ctrl_data[IDX_W-1:0];
            reg_val <= low_q;
          end
        end else begin
          cram_sel    <= 1'b0;
          rd_prefetch <= ~ctrl_data[6];
        end
      end else if (data_acc) begin
        addr   <= addr + 1'b1;
        second <= 1'b0;
      end else if (status_rd) begin
        second <= 1'b0;
      end
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, data_rd, data_wr, status_rd}));

  assert_first_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !second) |=> (!reg_wr && !rd_prefetch && $stable(addr)));

  assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> addr[7:0] == $past(low_q));

  assert_phase_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !second);

  assert_reg_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_strobes_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, rd_prefetch}));

  assert_cram_noreg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cram_sel) |-> !reg_wr);

  assert_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> addr == $past(addr) + 1'b1);

  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> $stable(addr) && !second);
endmodule

// File: tb/vdp_ctrl_port_tb.sv
module vdp_ctrl_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_wr = 1'b0, data_rd = 1'b0, data_wr = 1'b0, status_rd = 1'b0;
  logic [7:0] ctrl_data = 8'h00;
  logic [13:0] addr, addr_s;
  logic cram_sel, cram_s, pf, pf_s, rw, rw_s;
  logic [3:0] idx, idx_s;
  logic [7:0] val, val_s;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vdp_ctrl_port u_dut (.clk, .rst_n, .ctrl_wr, .ctrl_data, .data_rd, .data_wr, .status_rd,
    .addr(addr), .cram_sel(cram_sel), .rd_prefetch(pf), .reg_wr(rw), .reg_idx(idx), .reg_val(val));

  vdp_ctrl_port #(.EXTENDED(1'b0)) u_std (.clk, .rst_n, .ctrl_wr, .ctrl_data, .data_rd, .data_wr,
    .status_rd, .addr(addr_s), .cram_sel(cram_s), .rd_prefetch(pf_s), .reg_wr(rw_s),
    .reg_idx(idx_s), .reg_val(val_s));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl(logic [7:0] b);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_data = b;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic pulse_rd();  @(negedge clk); data_rd = 1'b1;   @(negedge clk); data_rd = 1'b0;   endtask
  task automatic pulse_wr();  @(negedge clk); data_wr = 1'b1;   @(negedge clk); data_wr = 1'b0;   endtask
  task automatic pulse_st();  @(negedge clk); status_rd = 1'b1; @(negedge clk); status_rd = 1'b0; endtask

  task automatic t_reset();
    chk("R1 addr", addr, 0);
    chk("R1 cram", cram_sel, 0);
    chk("R1 reg_wr", rw, 0);
    chk("R1 prefetch", pf, 0);
  endtask

  task automatic t_read_setup();
    ctrl(8'h34);
    chk("R2 addr hold", addr, 0);
    chk("R2 no strobe", {rw, pf}, 0);
    ctrl(8'h12);
    chk("R3 addr", addr, 14'h1234);
    chk("R7 prefetch", pf, 1);
    chk("R7 cram clear", cram_sel, 0);
    @(negedge clk);
    chk("R7 pulse one cycle", pf, 0);
  endtask

  task automatic t_regwrite();
    ctrl(8'hAB); ctrl(8'h87);
    chk("R5 reg_wr", rw, 1);
    chk("R5 idx", idx, 7);
    chk("R5 val", val, 8'hAB);
    chk("R3 addr on reg write", addr, 14'h07AB);
    chk("R5 no prefetch", pf, 0);
    @(negedge clk);
    chk("R5 pulse one cycle", rw, 0);
  endtask

  task automatic t_write_setup_phase();
    ctrl(8'h55); ctrl(8'h40);
    chk("R8 addr", addr, 14'h0055);
    chk("R8 no strobe", {rw, pf}, 0);
    ctrl(8'h99);
    chk("R4 lone write no load", addr, 14'h0055);
    chk("R4 no strobe", {rw, pf}, 0);
    ctrl(8'h01);
    chk("R4 pair resumes", addr, 14'h0199);
    chk("R4 prefetch", pf, 1);
  endtask

  task automatic t_cram();
    ctrl(8'h10); ctrl(8'hC2);
    chk("R6 cram set", cram_sel, 1);
    chk("R6 no reg_wr", rw, 0);
    chk("R3 addr on cram", addr, 14'h0210);
    chk("R6 std reg_wr", rw_s, 1);
    chk("R6 std idx/val", {idx_s, val_s}, {4'h2, 8'h10});
    chk("R6 std cram", cram_s, 0);
    ctrl(8'h00); ctrl(8'h40);
    chk("R8 cram cleared", cram_sel, 0);
  endtask

  task automatic t_increment();
    ctrl(8'hFE); ctrl(8'h7F);
    chk("R9 base", addr, 14'h3FFE);
    pulse_wr();
    chk("R9 write step", addr, 14'h3FFF);
    pulse_rd();
    chk("R9 wrap", addr, 14'h0000);
  endtask

  task automatic t_phase_reset();
    ctrl(8'h00); ctrl(8'h00);
    ctrl(8'h22); pulse_rd();
    chk("R10 data read step", addr, 14'h0001);
    ctrl(8'h33); ctrl(8'h01);
    chk("R10 after data read", addr, 14'h0133);
    ctrl(8'h44); pulse_st();
    chk("R10 status keeps addr", addr, 14'h0133);
    ctrl(8'h66); ctrl(8'h41);
    chk("R10 after status", addr, 14'h0166);
    ctrl(8'h77); pulse_wr();
    chk("R10 data write step", addr, 14'h0167);
    ctrl(8'h88); ctrl(8'h02);
    chk("R10 after data write", addr, 14'h0288);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_setup();
    t_regwrite();
    t_write_setup_phase();
    t_cram();
    t_increment();
    t_phase_reset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule